// File: doc/BRIEF.md
# Sign-Magnitude Adder with Saturation

This block adds two signed words held in sign-magnitude form: the top bit carries the sign (1 for negative) and the bits below it hold the absolute value. Inside, each operand is turned into a two's complement value one bit wider than the word. The two values are summed in that wider adder, which cannot wrap. The wide sum is then turned back into sign-magnitude form.

Any true sum whose magnitude exceeds the largest magnitude the word can hold raises a direction flag. The result then saturates to that largest magnitude, with the sign of the true sum. A result of zero is always given with a cleared sign bit. This holds whichever zero encodings went in.

A parameter chooses between a purely combinational output and a single output register. The registered variant captures a result only on cycles where the input is marked valid, and it flags that result valid on the following cycle.

Top module: `sm_adder`

## Requirements
- R1: Operands use bit N-1 as the sign (1 = negative) and bits N-2..0 as the magnitude; an operand with sign 1 and magnitude 0 has value zero.
- R2: When the true sum S of the two operand values satisfies |S| <= 2^(N-1)-1, sum_sm holds S exactly in sign-magnitude form and all three flags are 0.
- R3: A zero result is always emitted with the sign bit 0; sum_sm never carries sign 1 with magnitude 0.
- R4: When S > 2^(N-1)-1, pos_ovf is 1, neg_ovf is 0, and sum_sm is sign 0 with all magnitude bits 1.
- R5: When S < -(2^(N-1)-1), including S = -2^(N-1) exactly, neg_ovf is 1, pos_ovf is 0, and sum_sm is sign 1 with all magnitude bits 1.
- R6: ovf equals pos_ovf OR neg_ovf, and pos_ovf and neg_ovf are never both 1.
- R7: With REGISTERED=1, a result sampled at a clock edge where in_valid is 1 appears on the outputs after that edge, with out_valid 1. After an edge where in_valid is 0, out_valid is 0 and sum_sm and the flags keep their previous values.
- R8: With REGISTERED=0, the outputs follow the operands combinationally and out_valid equals in_valid.
- R9: With REGISTERED=1, while rst_n is 0, out_valid, sum_sm and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are valid this cycle |
| a_sm | input | N | First operand, sign-magnitude |
| b_sm | input | N | Second operand, sign-magnitude |
| out_valid | output | 1 | Result on the outputs is valid |
| sum_sm | output | N | Sum, sign-magnitude, saturated |
| ovf | output | 1 | Sum did not fit in either direction |
| pos_ovf | output | 1 | Sum exceeded the largest positive magnitude |
| neg_ovf | output | 1 | Sum fell below the most negative magnitude |

## Verification
Two things can happen in the same cycle: saturation and the sign cleanup of the result. The sharpest case is a sum of exactly -2^(N-1). A wide adder treats this as a legal two's complement value, yet its sign-magnitude form has zero magnitude bits and would look like negative zero. Sweeping every pair of codes reaches that pair (for example -31 plus -1) together with sums of both zero encodings. Each output is compared with an integer model, which must give saturation to sign 1 and all-ones magnitude with neg_ovf set, never a negative zero.

// File: rtl/sm_add_pkg.sv
package sm_add_pkg;
    localparam int unsigned SM_DEFAULT_W = 6;

    typedef enum logic [1:0] {
        FIT_OK   = 2'b00,
        FIT_HIGH = 2'b01,
        FIT_LOW  = 2'b10
    } fit_e;
endpackage

// File: rtl/sm_to_tc.sv
module sm_to_tc #(
    parameter int unsigned N = 6
) (
    input  logic [N-1:0] sm_in,
    output logic [N:0]   tc_out
);
    localparam int unsigned WW = N + 1;

    logic [WW-1:0] mag_ext;

    always_comb begin
        mag_ext = {2'b00, sm_in[N-2:0]};
        if (sm_in[N-1]) begin
            tc_out = ~mag_ext + {{(WW-1){1'b0}}, 1'b1};
        end else begin
            tc_out = mag_ext;
        end
    end
endmodule

// File: rtl/tc_to_sm.sv
module tc_to_sm
    import sm_add_pkg::*;
#(
    parameter int unsigned N = 6
) (
    input  logic [N:0]   wide_in,
    output logic [N-1:0] sm_out,
    output logic         hi_flag,
    output logic         lo_flag,
    output logic         any_flag
);
    localparam int unsigned MW = N - 1;
    localparam logic [MW-1:0] MAG_MAX = {MW{1'b1}};
    localparam logic [N:0]    MOST_NEG = {2'b11, {MW{1'b0}}};

    fit_e          fit;
    logic          at_min;
    logic [MW-1:0] mag;

    always_comb begin
        at_min = (wide_in == MOST_NEG);
        unique case (wide_in[N:N-1])
            2'b01:   fit = FIT_HIGH;
            2'b10:   fit = FIT_LOW;
            default: fit = at_min ? FIT_LOW : FIT_OK;
        endcase

        any_flag = (wide_in[N] ^ wide_in[N-1]) | at_min;
        hi_flag  = (fit == FIT_HIGH);
        lo_flag  = (fit == FIT_LOW);

        if (wide_in[N-1]) begin
            mag = ~wide_in[MW-1:0] + {{(MW-1){1'b0}}, 1'b1};
        end else begin
            mag = wide_in[MW-1:0];
        end

        unique case (fit)
            FIT_HIGH: sm_out = {1'b0, MAG_MAX};
            FIT_LOW:  sm_out = {1'b1, MAG_MAX};
            default:  sm_out = {(wide_in[N-1] && (mag != '0)), mag};
        endcase
    end
endmodule

// File: rtl/sm_adder.sv
module sm_adder #(
    parameter int unsigned N          = sm_add_pkg::SM_DEFAULT_W,
    parameter bit          REGISTERED = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [N-1:0] a_sm,
    input  logic [N-1:0] b_sm,
    output logic         out_valid,
    output logic [N-1:0] sum_sm,
    output logic         ovf,
    output logic         pos_ovf,
    output logic         neg_ovf
);
    localparam int unsigned WW = N + 1;

    typedef struct packed {
        logic         vld;
        logic [N-1:0] sum;
        logic         hi;
        logic         lo;
        logic         any;
    } res_t;

    logic [WW-1:0] a_tc, b_tc, wide_sum;
    logic [N-1:0]  conv_sm;
    logic          conv_hi, conv_lo, conv_any;
    res_t          res_d;
    res_t          res_out;

    sm_to_tc #(.N(N)) u_cvt_a (.sm_in(a_sm), .tc_out(a_tc));
    sm_to_tc #(.N(N)) u_cvt_b (.sm_in(b_sm), .tc_out(b_tc));

    assign wide_sum = a_tc + b_tc;

    tc_to_sm #(.N(N)) u_back (
        .wide_in (wide_sum),
        .sm_out  (conv_sm),
        .hi_flag (conv_hi),
        .lo_flag (conv_lo),
        .any_flag(conv_any)
    );

    always_comb begin
        res_d.vld = in_valid;
        res_d.sum = conv_sm;
        res_d.hi  = conv_hi;
        res_d.lo  = conv_lo;
        res_d.any = conv_any;
    end

    generate
        if (REGISTERED) begin : g_reg
            res_t res_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    res_q <= '0;
                end else begin
                    res_q.vld <= res_d.vld;
                    if (res_d.vld) begin
                        res_q.sum <= res_d.sum;
                        res_q.hi  <= res_d.hi;
                        res_q.lo  <= res_d.lo;
                        res_q.any <= res_d.any;
                    end
                end
            end
            assign res_out = res_q;
        end else begin : g_comb
            assign res_out = res_d;
        end
    endgenerate

    assign out_valid = res_out.vld;
    assign sum_sm    = res_out.sum;
    assign pos_ovf   = res_out.hi;
    assign neg_ovf   = res_out.lo;
    assign ovf       = res_out.any;
endmodule

// File: rtl/sm_adder_chk.sv
module sm_adder_chk #(
    parameter int unsigned N          = 6,
    parameter bit          REGISTERED = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         out_valid,
    input logic [N-1:0] sum_sm,
    input logic         ovf,
    input logic         pos_ovf,
    input logic         neg_ovf
);
    localparam logic [N-2:0] ALL1 = {(N-1){1'b1}};

    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pos_ovf, neg_ovf}));

    assert_ovf_combined_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf == (pos_ovf | neg_ovf));

    assert_no_negative_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sum_sm != {1'b1, {(N-1){1'b0}}});

    assert_pos_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pos_ovf |-> (sum_sm == {1'b0, ALL1}));

    assert_neg_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        neg_ovf |-> (sum_sm == {1'b1, ALL1}));

    generate
        if (REGISTERED) begin : g_reg_chk
            assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);

            assert_idle_drops_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);

            assert_idle_holds_sum_R7: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> ($stable(sum_sm) && $stable(ovf)));
        end else begin : g_comb_chk
            assert_valid_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid == in_valid);
        end
    endgenerate
endmodule

bind sm_adder sm_adder_chk #(.N(N), .REGISTERED(REGISTERED)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .out_valid(out_valid),
    .sum_sm   (sum_sm),
    .ovf      (ovf),
    .pos_ovf  (pos_ovf),
    .neg_ovf  (neg_ovf)
);

// File: tb/tb_sm_adder.sv
`timescale 1ns/1ps
module tb_sm_adder;
    localparam int N = 6;
    localparam int MAXM = (1 << (N - 1)) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [N-1:0] a_sm = '0, b_sm = '0;

    logic         r_vld, r_ovf, r_pos, r_neg;
    logic [N-1:0] r_sum;
    logic         c_vld, c_ovf, c_pos, c_neg;
    logic [N-1:0] c_sum;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    sm_adder #(.N(N), .REGISTERED(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_sm(a_sm), .b_sm(b_sm),
        .out_valid(r_vld), .sum_sm(r_sum), .ovf(r_ovf), .pos_ovf(r_pos), .neg_ovf(r_neg));

    sm_adder #(.N(N), .REGISTERED(1'b0)) dut_comb (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_sm(a_sm), .b_sm(b_sm),
        .out_valid(c_vld), .sum_sm(c_sum), .ovf(c_ovf), .pos_ovf(c_pos), .neg_ovf(c_neg));

    function automatic int sm_val(input logic [N-1:0] x);
        int m;
        m = int'(x[N-2:0]);
        return x[N-1] ? -m : m;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model(input logic [N-1:0] a, input logic [N-1:0] b,
                         output logic [N-1:0] es, output logic ep, output logic en);
        int s;
        s = sm_val(a) + sm_val(b);
        ep = 1'b0; en = 1'b0;
        if (s > MAXM) begin
            es = {1'b0, {(N-1){1'b1}}}; ep = 1'b1;
        end else if (s < -MAXM) begin
            es = {1'b1, {(N-1){1'b1}}}; en = 1'b1;
        end else if (s < 0) begin
            es = {1'b1, (N-1)'(-s)};
        end else begin
            es = {1'b0, (N-1)'(s)};
        end
    endtask

    initial begin : watchdog
        repeat (60000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [N-1:0] es, hold;
        logic ep, en;

        repeat (3) @(negedge clk);
        // R9 reset state of the registered variant
        chk("R9 valid", int'(r_vld), 0);
        chk("R9 sum", int'(r_sum), 0);
        chk("R9 flags", int'({r_ovf, r_pos, r_neg}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int ia = 0; ia < (1 << N); ia++) begin
            for (int ib = 0; ib < (1 << N); ib++) begin
                a_sm = N'(ia); b_sm = N'(ib); in_valid = 1'b1;
                model(a_sm, b_sm, es, ep, en);
                #1;
                // R1 R2 R3 R4 R5 combinational variant, R8 passthrough
                chk("R2/R3 comb sum", int'(c_sum), int'(es));
                chk("R4 comb pos_ovf", int'(c_pos), int'(ep));
                chk("R5 comb neg_ovf", int'(c_neg), int'(en));
                chk("R6 comb ovf", int'(c_ovf), int'(ep | en));
                chk("R8 comb valid", int'(c_vld), 1);
                @(negedge clk);
                // R1 R2 R7 registered variant, one edge later
                chk("R2 reg sum", int'(r_sum), int'(es));
                chk("R6 reg flags", int'({r_ovf, r_pos, r_neg}), int'({ep | en, ep, en}));
                chk("R7 reg valid", int'(r_vld), 1);
            end
        end

        // R1 both zero encodings give zero with cleared sign (R3)
        a_sm = {1'b1, {(N-1){1'b0}}}; b_sm = '0; in_valid = 1'b1;
        #1 chk("R1 negzero plus zero", int'(c_sum), 0);
        // R5 exact most negative sum: -31 + -1
        a_sm = {1'b1, {(N-1){1'b1}}}; b_sm = {1'b1, {(N-2){1'b0}}, 1'b1};
        #1 chk("R5 min sum neg_ovf", int'(c_neg), 1);
        chk("R5 min sum saturates", int'(c_sum), int'({1'b1, {(N-1){1'b1}}}));
        @(negedge clk);
        hold = r_sum;

        // R7 idle cycle: inputs change, registered outputs hold, valid drops
        in_valid = 1'b0; a_sm = N'(3); b_sm = N'(4);
        #1 chk("R8 comb valid low", int'(c_vld), 0);
        @(negedge clk);
        chk("R7 idle valid", int'(r_vld), 0);
        chk("R7 idle hold sum", int'(r_sum), int'(hold));
        chk("R7 idle hold neg_ovf", int'(r_neg), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule